// File: doc/BRIEF.md
# LPDDR1 Power-Up Initialization Sequencer

This block brings a low-power DDR1 memory from power-on to normal operation without software involvement. A one-cycle start pulse launches a fixed command stream. It begins with a NOP and then holds the bus idle for the stabilisation wait, which is 200 µs by default. A second NOP follows, then a precharge of all banks and two auto-refreshes. The extended mode register is written next, followed by the main mode register. The sequencer then enters normal mode and presents the refresh-interval reload value for the refresh engine. Clock frequency, wait length, refresh interval, inter-command gaps and both mode register values are parameters.

The core is a state machine with these states: IDLE (after reset), NOP_A (first NOP), WAIT (stabilisation wait), NOP_B (second NOP), PREA (precharge all), GAP_RP, REF (auto-refresh), GAP_RFC, EMRS, GAP_MRD1, MRS, GAP_MRD2 and DONE.

The transitions are:
- IDLE or DONE goes to NOP_A on start.
- NOP_A goes to WAIT.
- WAIT goes to NOP_B when the timer expires.
- NOP_B goes to PREA.
- PREA goes to GAP_RP.
- GAP_RP goes to REF when the timer expires.
- REF goes to GAP_RFC.
- GAP_RFC goes to REF after the first refresh, and to EMRS after the second, once the timer expires.
- EMRS goes to GAP_MRD1.
- GAP_MRD1 goes to MRS when the timer expires.
- MRS goes to GAP_MRD2.
- GAP_MRD2 goes to DONE when the timer expires.

A single shared down-counter times every wait and gap. Commands appear on the pins as {RAS#, CAS#, WE#}.

Top module: `lpinit_seq`

## Requirements
- R1: After reset the block drives command NOP (3'b111), bank address 0, address 0, busy low, done low and refresh value 0.
- R2: A start pulse accepted in IDLE or DONE makes busy high in the next cycle, and that cycle carries a NOP.
- R3: The second NOP comes WAIT_CYC+1 cycles after the first one, where WAIT_CYC = round(CLK_KHZ × WAIT_US / 1000) using round-to-nearest division. The precharge follows the second NOP in the next cycle.
- R4: The precharge-all command is 3'b010, with address bit 10 set, all other address bits 0 and bank address 0.
- R5: Exactly two auto-refresh commands (3'b001) are issued. The first comes TRP_CYC+1 cycles after the precharge and the second comes TRFC_CYC+1 cycles after the first.
- R6: The extended mode register write (command 3'b000) comes TRFC_CYC+1 cycles after the second refresh. It uses bank address 3'b010 (BA[1]=1, BA[0]=0) and address EMR_VAL.
- R7: The mode register write (command 3'b000) comes TMRD_CYC+1 cycles after the extended one. It uses bank address 0 and address MR_VAL.
- R8: Done rises and busy falls TMRD_CYC+1 cycles after the mode register write. While done is high, the refresh output equals round(TREFI_NS × CLK_KHZ / 1e6); before that it is 0.
- R9: Whenever busy is low, the command output is NOP.
- R10: A start pulse received while busy is ignored, so the command stream keeps its timing.
- R11: Done stays high until a new start is accepted, and it drops in the cycle busy rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launches the sequence when not busy |
| cmd_o | output | 3 | {RAS#, CAS#, WE#} command code |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row / mode register address |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Normal mode entered |
| refi_o | output | REFI_W | Refresh interval reload value in clock cycles |

## Verification
The assertions assume that start is a clean synchronous level and that every gap parameter is at least one cycle. Under that assumption each timer load is followed by a count-down to expiry. The stimulus respects both conditions. It uses the default gap values and drives start only between clock edges. Random idle lengths come before each start, and spurious start pulses land at random points inside the busy window. Directed pulses are also placed at the first and the last busy cycle.

// File: rtl/lpinit_pkg.sv
package lpinit_pkg;

    // {RAS#, CAS#, WE#}
    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_PREA,
        OP_REF,
        OP_EMRS,
        OP_MRS
    } op_e;

    localparam int unsigned REF_COUNT = 2;

    function automatic int unsigned round_div(input int unsigned num, input int unsigned den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/lpinit_timer.sv
module lpinit_timer #(
    parameter int unsigned TW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          last_o
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == TW'(1));

    // R3: an unloaded nonzero count moves down by exactly one per cycle
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lpinit_fsm.sv
module lpinit_fsm
    import lpinit_pkg::*;
#(
    parameter int unsigned TW       = 14,
    parameter int unsigned WAIT_CYC = 10000,
    parameter int unsigned TRP_CYC  = 2,
    parameter int unsigned TRFC_CYC = 4,
    parameter int unsigned TMRD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          tmr_last_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output op_e           op_o,
    output logic          busy_o,
    output logic          done_o
);

    typedef enum logic [3:0] {
        S_IDLE, S_NOP_A, S_WAIT, S_NOP_B, S_PREA, S_GAP_RP, S_REF,
        S_GAP_RFC, S_EMRS, S_GAP_MRD1, S_MRS, S_GAP_MRD2, S_DONE
    } state_e;

    state_e     state_q, state_d;
    logic [1:0] refs_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE: if (start_i) state_d = S_NOP_A;
            S_NOP_A:    state_d = S_WAIT;
            S_WAIT:     if (tmr_last_i) state_d = S_NOP_B;
            S_NOP_B:    state_d = S_PREA;
            S_PREA:     state_d = S_GAP_RP;
            S_GAP_RP:   if (tmr_last_i) state_d = S_REF;
            S_REF:      state_d = S_GAP_RFC;
            S_GAP_RFC:  if (tmr_last_i)
                            state_d = (refs_q == 2'(REF_COUNT)) ? S_EMRS : S_REF;
            S_EMRS:     state_d = S_GAP_MRD1;
            S_GAP_MRD1: if (tmr_last_i) state_d = S_MRS;
            S_MRS:      state_d = S_GAP_MRD2;
            S_GAP_MRD2: if (tmr_last_i) state_d = S_DONE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            refs_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_NOP_A)
                refs_q <= '0;
            else if (state_q == S_REF)
                refs_q <= refs_q + 1'b1;
        end
    end

    always_comb begin
        op_o       = OP_NOP;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        busy_o     = 1'b1;
        done_o     = 1'b0;
        unique case (state_q)
            S_IDLE: busy_o = 1'b0;
            S_DONE: begin
                busy_o = 1'b0;
                done_o = 1'b1;
            end
            S_NOP_A: begin
                tmr_load_o = 1'b1;
                tmr_val_o  = TW'(WAIT_CYC);
            end
            S_PREA: begin
                op_o       = OP_PREA;
                tmr_load_o = 1'b1;
                tmr_val_o  = TW'(TRP_CYC);
            end
            S_REF: begin
                op_o       = OP_REF;
                tmr_load_o = 1'b1;
                tmr_val_o  = TW'(TRFC_CYC);
            end
            S_EMRS: begin
                op_o       = OP_EMRS;
                tmr_load_o = 1'b1;
                tmr_val_o  = TW'(TMRD_CYC);
            end
            S_MRS: begin
                op_o       = OP_MRS;
                tmr_load_o = 1'b1;
                tmr_val_o  = TW'(TMRD_CYC);
            end
            default: ;
        endcase
    end

    // R5: mode programming starts only after exactly two refreshes
    p_two_refs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EMRS) |-> (refs_q == 2'(REF_COUNT)));

    // R3: the wait holds until the shared timer expires
    p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !tmr_last_i) |=> (state_q == S_WAIT));

    // R10: a start while busy never sends the machine back to the first NOP
    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q != S_GAP_MRD2) |=> (state_q != S_NOP_A));

endmodule

// File: rtl/lpinit_cmdgen.sv
module lpinit_cmdgen
    import lpinit_pkg::*;
#(
    parameter int unsigned        ADDR_W  = 13,
    parameter int unsigned        BA_W    = 3,
    parameter logic [ADDR_W-1:0]  MR_VAL  = '0,
    parameter logic [ADDR_W-1:0]  EMR_VAL = '0
) (
    input  op_e               op_i,
    output logic [2:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int unsigned AP_BIT = 10;

    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        unique case (op_i)
            OP_NOP: ;
            OP_PREA: begin
                cmd_o          = CMD_PRE;
                addr_o[AP_BIT] = 1'b1;
            end
            OP_REF: cmd_o = CMD_REF;
            OP_EMRS: begin
                cmd_o   = CMD_MRS;
                ba_o[1] = 1'b1;
                addr_o  = EMR_VAL;
            end
            OP_MRS: begin
                cmd_o  = CMD_MRS;
                addr_o = MR_VAL;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lpinit_seq.sv
module lpinit_seq
    import lpinit_pkg::*;
#(
    parameter int unsigned       CLK_KHZ  = 50000,
    parameter int unsigned       WAIT_US  = 200,
    parameter int unsigned       TREFI_NS = 7800,
    parameter int unsigned       TRP_CYC  = 2,
    parameter int unsigned       TRFC_CYC = 4,
    parameter int unsigned       TMRD_CYC = 2,
    parameter int unsigned       ADDR_W   = 13,
    parameter int unsigned       BA_W     = 3,
    parameter int unsigned       REFI_W   = 16,
    parameter logic [ADDR_W-1:0] MR_VAL   = 13'h0032,
    parameter logic [ADDR_W-1:0] EMR_VAL  = 13'h0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic [2:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [REFI_W-1:0] refi_o
);

    localparam int unsigned WAIT_CYC = round_div(CLK_KHZ * WAIT_US, 1000);
    localparam int unsigned REFI_CYC = round_div(TREFI_NS * CLK_KHZ, 1000000);
    localparam int unsigned GAP_MAX  = (TRP_CYC > TRFC_CYC)
                                     ? ((TRP_CYC > TMRD_CYC) ? TRP_CYC : TMRD_CYC)
                                     : ((TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC);
    localparam int unsigned CNT_MAX  = (WAIT_CYC > GAP_MAX) ? WAIT_CYC : GAP_MAX;
    localparam int unsigned TW       = $clog2(CNT_MAX + 1);

    logic          tmr_load, tmr_last;
    logic [TW-1:0] tmr_val;
    op_e           op;

    lpinit_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .last_o (tmr_last)
    );

    lpinit_fsm #(
        .TW       (TW),
        .WAIT_CYC (WAIT_CYC),
        .TRP_CYC  (TRP_CYC),
        .TRFC_CYC (TRFC_CYC),
        .TMRD_CYC (TMRD_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tmr_last_i (tmr_last),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .op_o       (op),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    lpinit_cmdgen #(
        .ADDR_W  (ADDR_W),
        .BA_W    (BA_W),
        .MR_VAL  (MR_VAL),
        .EMR_VAL (EMR_VAL)
    ) u_cmd (
        .op_i   (op),
        .cmd_o  (cmd_o),
        .ba_o   (ba_o),
        .addr_o (addr_o)
    );

    assign refi_o = done_o ? REFI_W'(REFI_CYC) : '0;

    // R9: no command other than NOP outside the sequence
    p_idle_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cmd_o == CMD_NOP));

    // R8: busy and done never overlap
    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R2: an accepted start raises busy
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R11: done holds until a start arrives
    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R5: refreshes are never back to back
    p_ref_spaced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_REF) |=> (cmd_o != CMD_REF));

    // R6 / R7: a mode write carries one of the two legal bank/address pairs
    p_mode_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_MRS) |->
            ((ba_o == '0 && addr_o == MR_VAL) || (ba_o == BA_W'(2) && addr_o == EMR_VAL)));

endmodule

// File: tb/lpinit_seq_test.sv
module lpinit_seq_test;

    localparam int CLK_KHZ  = 50000;
    localparam int WAIT_US  = 200;
    localparam int TREFI_NS = 7800;
    localparam int TRP      = 2;
    localparam int TRFC     = 4;
    localparam int TMRD     = 2;
    localparam logic [12:0] MRV  = 13'h0032;
    localparam logic [12:0] EMRV = 13'h0020;

    function automatic int rdiv(input int a, input int b);
        return (a + b / 2) / b;
    endfunction

    localparam int WAIT_CYC = rdiv(CLK_KHZ * WAIT_US, 1000);
    localparam int REFI     = rdiv(TREFI_NS * CLK_KHZ, 1000000);
    localparam int T_PRE    = WAIT_CYC + 3;
    localparam int T_REF1   = T_PRE + TRP + 1;
    localparam int T_REF2   = T_REF1 + TRFC + 1;
    localparam int T_EMRS   = T_REF2 + TRFC + 1;
    localparam int T_MRS    = T_EMRS + TMRD + 1;
    localparam int T_DONE   = T_MRS + TMRD + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cmd;
    logic [2:0]  ba;
    logic [12:0] addr;
    logic        busy, done;
    logic [15:0] refi;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lpinit_seq #(
        .CLK_KHZ(CLK_KHZ), .WAIT_US(WAIT_US), .TREFI_NS(TREFI_NS),
        .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD),
        .ADDR_W(13), .BA_W(3), .REFI_W(16), .MR_VAL(MRV), .EMR_VAL(EMRV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cmd_o(cmd), .ba_o(ba), .addr_o(addr),
        .busy_o(busy), .done_o(done), .refi_o(refi)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_once(input int idle, input int s0, input int s1, input int s2);
        int ev_t[8];
        int ev_c[8];
        int ev_b[8];
        int ev_a[8];
        int nev = 0;
        for (int i = 0; i < idle; i++) begin
            @(negedge clk);
            chk(cmd == 3'b111, "R9 idle cmd", cmd, 3'b111);
        end
        start = 1'b1;
        for (int t = 1; t <= T_DONE + 1; t++) begin
            @(negedge clk);
            if (cmd != 3'b111 && nev < 8) begin
                ev_t[nev] = t; ev_c[nev] = cmd; ev_b[nev] = ba; ev_a[nev] = addr;
                nev++;
            end
            if (t == 1) begin
                chk(busy == 1'b1 && cmd == 3'b111, "R2 busy+NOP after start", {busy, cmd}, 4'b1111);
                chk(done == 1'b0, "R11 done drops on start", done, 0);
            end
            if (t == T_DONE - 1) begin
                chk(done == 1'b0 && busy == 1'b1, "R8 still busy", {busy, done}, 2'b10);
                chk(refi == 16'd0, "R8 refresh value before done", refi, 0);
            end
            if (t == T_DONE) begin
                chk(done == 1'b1 && busy == 1'b0, "R8 done/busy", {busy, done}, 2'b01);
                chk(refi == 16'(REFI), "R8 refresh value", refi, REFI);
            end
            if (t == T_DONE + 1)
                chk(done == 1'b1, "R11 done holds", done, 1);
            start = (t == s0 || t == s1 || t == s2) ? 1'b1 : 1'b0;
        end
        start = 1'b0;
        chk(nev == 5, "R5/R10 command count", nev, 5);
        if (nev == 5) begin
            chk(ev_t[0] == T_PRE, "R3 wait length", ev_t[0], T_PRE);
            chk(ev_c[0] == 3'b010 && ev_a[0] == 1 << 10 && ev_b[0] == 0, "R4 precharge-all",
                ev_a[0], 1 << 10);
            chk(ev_c[1] == 3'b001 && ev_t[1] == T_REF1, "R5 first refresh", ev_t[1], T_REF1);
            chk(ev_c[2] == 3'b001 && ev_t[2] == T_REF2, "R5 second refresh", ev_t[2], T_REF2);
            chk(ev_c[3] == 3'b000 && ev_t[3] == T_EMRS, "R6 ext mode time", ev_t[3], T_EMRS);
            chk(ev_b[3] == 2 && ev_a[3] == int'(EMRV), "R6 ext mode bank/addr", ev_a[3], EMRV);
            chk(ev_c[4] == 3'b000 && ev_t[4] == T_MRS, "R7 mode time", ev_t[4], T_MRS);
            chk(ev_b[4] == 0 && ev_a[4] == int'(MRV), "R7 mode bank/addr", ev_a[4], MRV);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(cmd == 3'b111 && ba == 0 && addr == 0, "R1 reset command", cmd, 3'b111);
        chk(busy == 1'b0 && done == 1'b0 && refi == 0, "R1 reset flags", {busy, done}, 0);
        rst_n = 1'b1;
        // directed: spurious starts on first and last busy cycles (R10)
        run_once(4, 1, T_DONE - 1, 5);
        for (int r = 0; r < 3; r++) begin
            int s0 = 2 + int'($urandom % (T_DONE - 3));
            int s1 = 2 + int'($urandom % (T_DONE - 3));
            int s2 = 2 + int'($urandom % 20);
            run_once(1 + int'($urandom % 10), s0, s1, s2);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule